// File: doc/BRIEF.md
# Interrupt Request Arbitration Core

This block sits between eight external interrupt request pins and a processor's single interrupt input. It watches each pin for a low-to-high transition and records an accepted transition as a pending request, unless that line is masked at that moment. It then decides whether the processor should be told. It sends a one-cycle pulse on its interrupt output only when no line at the same or a higher number is already being serviced. A higher line number means a higher priority.

When the processor acknowledges, the core picks the highest pending line and clears its request. It marks the line as in service, or with automatic end-of-interrupt it retires the line at once. One cycle later it presents an 8-bit vector, formed as the vector base OR the line number. On a master whose chosen line is mapped to a cascaded secondary controller, it raises a select flag instead, and that controller supplies the vector. End-of-interrupt strobes from the surrounding register logic clear in-service bits. After each one the highest pending line is checked again and may cause a new pulse.

Top module: `irq_arb_core`

## Requirements
- R1: Only a rising edge on a pin (high now, low in the previous cycle) creates a request. A pin held high creates no further request. After reset the previous pin state is taken as all low.
- R2: If the line's mask bit is 1 in the cycle of the rising edge, the edge is discarded. Clearing the mask later while the pin stays high creates no request.
- R3: An accepted edge sets its bit in `pending` in the next cycle. `int_pulse` is high in that next cycle only if, for the highest line accepted, every `in_service` bit at that line number or above is 0. Within one cycle the acknowledge is applied first, then the end-of-interrupt, then new edges, and this check uses the in-service value after the first two.
- R4: On `ack_stb`, the highest-numbered set bit of `pending` is chosen and cleared. In the next cycle `vec_valid` is 1 for one cycle and `vec_out` equals `vec_base` bitwise-OR the 3-bit line number.
- R5: With `auto_eoi` at 0, the chosen line's `in_service` bit is set. With `auto_eoi` at 1, that bit is cleared instead, and the acknowledge counts as an end-of-interrupt for the re-check of R7.
- R6: If `is_master` is 1 and bit L of `cascade_map` is 1 for the chosen line L, the cycle after the acknowledge shows `slave_sel` = 1 and `vec_out` = 0.
- R7: `eoi_stb` clears `in_service` bit `eoi_line`. After any end-of-interrupt, if `pending` is still non-zero, `int_pulse` is raised next cycle when no `in_service` bit at or above the highest pending line is set.
- R8: An acknowledge while `pending` is 0 gives `vec_valid` = 1, `vec_out` = `vec_base` OR 7 and `slave_sel` = 0, and changes neither `pending` nor `in_service`.
- R9: `int_pulse`, `vec_valid` and `slave_sel` are registered. Each is high only in the cycle after the event that causes it. `vec_out` is 0 whenever `vec_valid` is 0.
- R10: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 8 | Interrupt request pins |
| line_mask | input | 8 | Per-line mask, 1 discards edges |
| vec_base | input | 8 | Base ORed with the line number to form the vector |
| is_master | input | 1 | Controller acts as master of a cascade |
| cascade_map | input | 8 | Lines that lead to a secondary controller |
| auto_eoi | input | 1 | Retire lines at acknowledge |
| ack_stb | input | 1 | One-cycle acknowledge strobe |
| eoi_stb | input | 1 | One-cycle end-of-interrupt strobe |
| eoi_line | input | 3 | Line retired by `eoi_stb` |
| int_pulse | output | 1 | One-cycle interrupt pulse to the processor |
| vec_valid | output | 1 | Vector valid, cycle after acknowledge |
| vec_out | output | 8 | Interrupt vector |
| slave_sel | output | 1 | Vector to be supplied by the cascaded controller |
| pending | output | 8 | Request register |
| in_service | output | 8 | In-service register |

## Verification
Single-line edges, with the pin held afterwards, separate edge detection from level sensing. Masking then unmasking a held pin shows that masked edges are dropped and not deferred. Low-priority edges that arrive while a higher line is in service, and the end-of-interrupt sequences that follow, test the at-or-above in-service rule for both the edge path and the re-check path. Acknowledges with an empty request register, cascaded lines, automatic end-of-interrupt and a long random stretch of overlapping edges, acknowledges and end-of-interrupts exercise vector formation and the order of updates within a cycle.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    parameter int unsigned LINES = 8;
    parameter int unsigned VEC_W = 8;
    localparam int unsigned IDX_W = $clog2(LINES);

    typedef struct packed {
        logic [LINES-1:0] req;
        logic [LINES-1:0] isr;
        logic             pulse;
        logic             vec_valid;
        logic [VEC_W-1:0] vec;
        logic             slave_sel;
    } arb_state_t;

    // bits at index idx and above
    function automatic logic [LINES-1:0] at_or_above(input logic [IDX_W-1:0] idx);
        return ~((LINES'(1) << idx) - LINES'(1));
    endfunction
endpackage

// File: rtl/irq_rise_detect.sv
module irq_rise_detect #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pins,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = pins;
        rise   = pins & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/irq_top_find.sv
module irq_top_find #(
    parameter int unsigned N     = 8,
    parameter int unsigned IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     bits,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (bits[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_arb_core.sv
module irq_arb_core
    import irq_arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       irq_in,
    input  logic [7:0]       line_mask,
    input  logic [7:0]       vec_base,
    input  logic             is_master,
    input  logic [7:0]       cascade_map,
    input  logic             auto_eoi,
    input  logic             ack_stb,
    input  logic             eoi_stb,
    input  logic [2:0]       eoi_line,
    output logic             int_pulse,
    output logic             vec_valid,
    output logic [7:0]       vec_out,
    output logic             slave_sel,
    output logic [7:0]       pending,
    output logic [7:0]       in_service
);
    arb_state_t cur_q, nxt_d;

    logic [LINES-1:0] rise, accepted, req_after_ack, isr_after_ack, isr_after_eoi;
    logic             ack_found, rest_found, new_found, eoi_evt;
    logic [IDX_W-1:0] ack_idx, rest_idx, new_idx;

    irq_rise_detect #(.N(LINES)) u_rise (
        .clk(clk), .rst_n(rst_n), .pins(irq_in), .rise(rise)
    );

    assign accepted = rise & ~line_mask;

    irq_top_find #(.N(LINES), .IDX_W(IDX_W)) u_find_ack (
        .bits(cur_q.req), .found(ack_found), .idx(ack_idx)
    );
    irq_top_find #(.N(LINES), .IDX_W(IDX_W)) u_find_rest (
        .bits(req_after_ack), .found(rest_found), .idx(rest_idx)
    );
    irq_top_find #(.N(LINES), .IDX_W(IDX_W)) u_find_new (
        .bits(accepted), .found(new_found), .idx(new_idx)
    );

    always_comb begin
        nxt_d           = cur_q;
        nxt_d.pulse     = 1'b0;
        nxt_d.vec_valid = 1'b0;
        nxt_d.vec       = '0;
        nxt_d.slave_sel = 1'b0;
        req_after_ack   = cur_q.req;
        isr_after_ack   = cur_q.isr;
        eoi_evt         = 1'b0;

        // acknowledge first
        if (ack_stb) begin
            nxt_d.vec_valid = 1'b1;
            if (ack_found) begin
                req_after_ack[ack_idx] = 1'b0;
                if (auto_eoi) begin
                    isr_after_ack[ack_idx] = 1'b0;
                    eoi_evt = 1'b1;
                end else begin
                    isr_after_ack[ack_idx] = 1'b1;
                end
                if (is_master && cascade_map[ack_idx]) nxt_d.slave_sel = 1'b1;
                else nxt_d.vec = vec_base | VEC_W'(ack_idx);
            end else begin
                nxt_d.vec = vec_base | VEC_W'(LINES - 1);
            end
        end

        // then end-of-interrupt
        isr_after_eoi = isr_after_ack;
        if (eoi_stb) begin
            isr_after_eoi[eoi_line] = 1'b0;
            eoi_evt = 1'b1;
        end

        // then new edges
        nxt_d.req   = req_after_ack | accepted;
        nxt_d.isr   = isr_after_eoi;
        nxt_d.pulse = (eoi_evt && rest_found && ((isr_after_eoi & at_or_above(rest_idx)) == '0))
                   || (new_found && ((isr_after_eoi & at_or_above(new_idx)) == '0));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign int_pulse  = cur_q.pulse;
    assign vec_valid  = cur_q.vec_valid;
    assign vec_out    = cur_q.vec;
    assign slave_sel  = cur_q.slave_sel;
    assign pending    = cur_q.req;
    assign in_service = cur_q.isr;

    // R2
    masked_edge_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(rise & line_mask & ~cur_q.req)) |=> ((cur_q.req & $past(rise & line_mask & ~cur_q.req)) == '0));
    // R4
    ack_gives_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_stb |=> vec_valid);
    // R9
    vector_only_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(ack_stb));
    // R5
    service_set_by_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_q.isr & ~$past(cur_q.isr)) != '0) |-> ($past(ack_stb) && !$past(auto_eoi)));
    // R7
    eoi_clears_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_stb |=> !in_service[$past(eoi_line)]);
    // R8
    empty_ack_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_stb && cur_q.req == '0) |=> (vec_out == ($past(vec_base) | VEC_W'(LINES - 1)) && !slave_sel));
endmodule

// File: tb/test_irq_arb_core.sv
`timescale 1ns/100ps
module test_irq_arb_core;
    localparam int N = 8;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic [7:0] pins = '0, mask = '0, base = 8'h20, cmap = '0;
    logic       master = 1'b0, aeoi = 1'b0, ack = 1'b0, eoi = 1'b0;
    logic [2:0] eline = '0;
    logic       int_pulse, vec_valid, slave_sel;
    logic [7:0] vec_out, pending, in_service;

    always #2.5 clk = ~clk;

    irq_arb_core i_irq_arb_core (
        .clk(clk), .rst_n(rst_n), .irq_in(pins), .line_mask(mask), .vec_base(base),
        .is_master(master), .cascade_map(cmap), .auto_eoi(aeoi), .ack_stb(ack),
        .eoi_stb(eoi), .eoi_line(eline), .int_pulse(int_pulse), .vec_valid(vec_valid),
        .vec_out(vec_out), .slave_sel(slave_sel), .pending(pending), .in_service(in_service)
    );

    int total = 0, bad = 0, cycles = 0;
    int m_req = 0, m_isr = 0, m_prev = 0, m_vec = 0;
    int m_pulse = 0, m_vv = 0, m_ss = 0;
    int r, s, acc, top, ev, p;

    function automatic int msb(input int v);
        for (int i = N - 1; i >= 0; i--) if (v[i]) return i;
        return -1;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cycles, act, exp);
        end
    endtask

    // behavioural reference, one step per clock
    always @(posedge clk) begin
        if (!rst_n) begin
            m_req = 0; m_isr = 0; m_prev = 0; m_vec = 0; m_pulse = 0; m_vv = 0; m_ss = 0;
        end else begin
            r = m_req; s = m_isr; ev = 0; p = 0;
            acc = int'(pins) & ~m_prev & ~int'(mask) & 'hFF;
            m_vv = 0; m_ss = 0; m_vec = 0;
            if (ack) begin
                m_vv = 1;
                top = msb(r);
                if (top < 0) m_vec = int'(base) | 7;
                else begin
                    r = r & ~(1 << top);
                    if (aeoi) begin s = s & ~(1 << top); ev = 1; end
                    else s = s | (1 << top);
                    if (master && cmap[top]) m_ss = 1;
                    else m_vec = int'(base) | top;
                end
            end
            if (eoi) begin s = s & ~(1 << int'(eline)); ev = 1; end
            if (ev != 0 && r != 0) begin top = msb(r); if ((s >> top) == 0) p = 1; end
            if (acc != 0) begin top = msb(acc); if ((s >> top) == 0) p = 1; end
            m_req = r | acc; m_isr = s; m_pulse = p; m_prev = int'(pins);
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
        chk("R1 R2 R3 pending", int'(pending), m_req);
        chk("R5 R7 in_service", int'(in_service), m_isr);
        chk("R3 R7 R9 int_pulse", int'(int_pulse), m_pulse);
        chk("R4 R9 vec_valid", int'(vec_valid), m_vv);
        chk("R4 R6 R8 vec_out", int'(vec_out), m_vec);
        chk("R6 slave_sel", int'(slave_sel), m_ss);
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_ack();
        ack = 1'b1; @(negedge clk); ack = 1'b0;
    endtask

    task automatic do_eoi(input int line);
        eline = 3'(line); eoi = 1'b1; @(negedge clk); eoi = 1'b0;
    endtask

    initial begin
        wait_cyc(3);
        // R10: outputs idle in reset
        chk("R10 reset outputs", int'({int_pulse, vec_valid, slave_sel, vec_out, pending, in_service}), 0);
        rst_n = 1'b1;
        wait_cyc(2);

        // R1: single edge, then held high
        pins[3] = 1'b1; @(negedge clk);
        chk("R1 edge pulse", int'(int_pulse), 1);
        wait_cyc(3);
        chk("R1 held no pulse", int'(int_pulse), 0);

        // R2: masked edge dropped, unmask while held
        mask[5] = 1'b1; pins[5] = 1'b1; @(negedge clk);
        chk("R2 masked not latched", int'(pending[5]), 0);
        mask[5] = 1'b0; wait_cyc(2);
        chk("R2 unmask no request", int'(pending[5]), 0);

        // R4 R5: acknowledge line 3
        do_ack();
        chk("R4 vector line3", int'(vec_out), 'h23);
        chk("R5 in service 3", int'(in_service[3]), 1);

        // R3: lower line blocked, higher line passes
        pins[1] = 1'b1; @(negedge clk);
        chk("R3 lower blocked", int'(int_pulse), 0);
        pins[6] = 1'b1; @(negedge clk);
        chk("R3 higher pulses", int'(int_pulse), 1);
        do_ack();
        chk("R4 vector line6", int'(vec_out), 'h26);

        // R7: EOI re-checks pending
        do_eoi(6);
        chk("R7 still blocked by 3", int'(int_pulse), 0);
        do_eoi(3);
        chk("R7 re-check pulses", int'(int_pulse), 1);
        do_ack();
        do_eoi(1);
        wait_cyc(1);

        // R8: empty acknowledge
        do_ack();
        chk("R8 empty vector", int'(vec_out), 'h27);
        chk("R8 no state change", int'(pending), 0);

        // R6: cascaded line
        pins = '0; wait_cyc(1);
        master = 1'b1; cmap = 8'h04; pins[2] = 1'b1; wait_cyc(1);
        do_ack();
        chk("R6 slave select", int'(slave_sel), 1);
        chk("R6 vector zero", int'(vec_out), 0);
        do_eoi(2);

        // R5: automatic end-of-interrupt with a second request waiting
        aeoi = 1'b1; pins[4] = 1'b1; pins[0] = 1'b1; wait_cyc(2);
        do_ack();
        chk("R5 auto no service", int'(in_service), 0);
        chk("R5 auto re-check pulse", int'(int_pulse), 1);
        do_ack();
        aeoi = 1'b0;

        // overlapping strobes and random traffic
        for (int k = 0; k < 400; k++) begin
            pins   = 8'($urandom);
            mask   = 8'($urandom) & 8'($urandom);
            ack    = ($urandom % 4) == 0;
            eoi    = ($urandom % 4) == 0;
            eline  = 3'($urandom);
            aeoi   = ($urandom % 5) == 0;
            master = ($urandom % 2) == 0;
            cmap   = 8'($urandom);
            base   = 8'($urandom) & 8'hF8;
            @(negedge clk);
        end
        ack = 1'b0; eoi = 1'b0;
        wait_cyc(2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule